// File: doc/BRIEF.md
# Fully Associative LRU Translation Buffer

The block caches virtual-to-physical page mappings in a small set of fully associative slots. Each slot holds a page of its own size, a power of two given as an order (size = 2^order bytes). A lookup is purely combinational. It compares the incoming virtual address against the range held by every valid slot. It returns a hit flag and the translated physical address. The lookup can also mark the matching slot as most recently used.

Mappings enter through an insert port. The block places a new mapping in an unused slot whenever one exists. Only when every slot is occupied does it overwrite the least recently used mapping. Three maintenance commands remove mappings, and each takes effect at the next clock edge:
- drop everything;
- drop only the mappings not flagged global;
- drop the single mapping that the lookup address hits.

Top module: `tlb_lru_cache`

## Requirements
- R1: After reset every slot is unused, so no lookup hits until an insert has been made.
- R2: A valid slot matches a lookup address `va` when its virtual base is less than or equal to `va` and base + 2^order is greater than `va`. `hit_o` is the combinational OR of these matches.
- R3: On a hit, `pa_o` equals the physical base of the matching slot ORed with `va & (2^order - 1)`. When several slots match, the slot with the lowest index supplies the result. On a miss, `pa_o` is zero.
- R4: An insert writes the lowest-index unused slot if one exists. If all slots are valid, it overwrites the valid mapping that was used least recently.
- R5: A freshly inserted mapping becomes the most recently used one.
- R6: A lookup with `lookup_touch_i` high that hits makes the hit slot the most recently used. A lookup with it low, or one that misses, leaves the recency order unchanged.
- R7: `flush_all_i` marks every slot unused.
- R8: `flush_local_i` marks unused only the slots whose global flag is clear. Global slots keep their mapping and still hit afterwards.
- R9: `demap_i` frees the slot that a lookup of `lookup_va_i` would return. It does not change the recency order, and it has no effect when the address misses.
- R10: At most one of insert, touch, demap, flush-local and flush-all is requested in a cycle. Each state change is visible to lookups from the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lookup_va_i | input | ADDR_W | Lookup address, also the demap address |
| lookup_touch_i | input | 1 | Make the hit slot most recently used |
| hit_o | output | 1 | A valid slot covers `lookup_va_i` |
| pa_o | output | ADDR_W | Translated address, zero on miss |
| ins_valid_i | input | 1 | Insert request |
| ins_va_i | input | ADDR_W | Virtual base of the new page, aligned to its size |
| ins_pa_i | input | ADDR_W | Physical base of the new page, aligned to its size |
| ins_order_i | input | ORD_W | log2 of the page size in bytes |
| ins_global_i | input | 1 | Page survives `flush_local_i` |
| flush_all_i | input | 1 | Free every slot |
| flush_local_i | input | 1 | Free every non-global slot |
| demap_i | input | 1 | Free the slot hit by `lookup_va_i` |

## Verification
The assertions rely on three conditions on the inputs:
- no more than one of the five state-changing requests is active in any cycle;
- inserted bases are aligned to their page size;
- the page order is below `ADDR_W`.

The bench keeps to all three because every cycle passes through one task that drives a single operation code. That task derives each virtual and physical base by shifting a random index left by the chosen order, and it picks orders between 8 and 16. Overlapping pages are allowed and are driven on purpose to exercise the lowest-index rule.

// File: rtl/tlbf_pkg.sv
package tlbf_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_INSERT,
    OP_TOUCH,
    OP_DEMAP,
    OP_DROP_LOCAL,
    OP_DROP_ALL
  } op_e;
endpackage

// File: rtl/tlbf_lowest.sv
// Lowest set bit finder
module tlbf_lowest #(
  parameter int N     = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlbf_age.sv
// Recency ranks: 0 = most recent, N-1 = least recent; always a permutation
module tlbf_age #(
  parameter int N     = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] lru_idx_o
);
  logic [IDX_W-1:0] rank_q [N];
  logic [IDX_W-1:0] old_rank;

  assign old_rank = rank_q[touch_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) rank_q[i] <= IDX_W'(i);
    end else if (touch_i) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == touch_idx_i) rank_q[i] <= '0;
        else if (rank_q[i] < old_rank) rank_q[i] <= rank_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    lru_idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (rank_q[i] == IDX_W'(N - 1)) lru_idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_lru_cache.sv
module tlb_lru_cache
  import tlbf_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int ADDR_W    = 32,
  localparam int IDX_W    = $clog2(N_ENTRIES),
  localparam int ORD_W    = $clog2(ADDR_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lookup_va_i,
  input  logic              lookup_touch_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] pa_o,
  input  logic              ins_valid_i,
  input  logic [ADDR_W-1:0] ins_va_i,
  input  logic [ADDR_W-1:0] ins_pa_i,
  input  logic [ORD_W-1:0]  ins_order_i,
  input  logic              ins_global_i,
  input  logic              flush_all_i,
  input  logic              flush_local_i,
  input  logic              demap_i
);
  logic [N_ENTRIES-1:0] valid_q, glob_q, hit_vec, free_vec;
  logic [ADDR_W-1:0]    vbase_q [N_ENTRIES];
  logic [ADDR_W-1:0]    pbase_q [N_ENTRIES];
  logic [ORD_W-1:0]     ord_q   [N_ENTRIES];

  logic             any_hit, any_free, age_touch;
  logic [IDX_W-1:0] hit_idx, free_idx, lru_idx, ins_slot, age_idx;
  logic [ADDR_W-1:0] off_mask;
  op_e              op;

  // Range match per slot, one bit wider to hold base + size
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    logic [ADDR_W:0] span_end;
    assign span_end   = {1'b0, vbase_q[g]} + ((ADDR_W + 1)'(1) << ord_q[g]);
    assign hit_vec[g] = valid_q[g] && (vbase_q[g] <= lookup_va_i) &&
                        ({1'b0, lookup_va_i} < span_end);
  end

  assign free_vec = ~valid_q;

  tlbf_lowest #(.N(N_ENTRIES)) u_hit_pick (
    .vec_i(hit_vec), .found_o(any_hit), .idx_o(hit_idx)
  );

  tlbf_lowest #(.N(N_ENTRIES)) u_free_pick (
    .vec_i(free_vec), .found_o(any_free), .idx_o(free_idx)
  );

  always_comb begin
    if (flush_all_i)        op = OP_DROP_ALL;
    else if (flush_local_i) op = OP_DROP_LOCAL;
    else if (demap_i)       op = OP_DEMAP;
    else if (ins_valid_i)   op = OP_INSERT;
    else if (lookup_touch_i) op = OP_TOUCH;
    else                    op = OP_IDLE;
  end

  assign ins_slot  = any_free ? free_idx : lru_idx;
  assign age_touch = (op == OP_INSERT) || (op == OP_TOUCH && any_hit);
  assign age_idx   = (op == OP_INSERT) ? ins_slot : hit_idx;

  tlbf_age #(.N(N_ENTRIES)) u_age (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .touch_i(age_touch), .touch_idx_i(age_idx), .lru_idx_o(lru_idx)
  );

  assign off_mask = (ADDR_W'(1) << ord_q[hit_idx]) - 1'b1;
  assign hit_o    = any_hit;
  assign pa_o     = any_hit ? (pbase_q[hit_idx] | (lookup_va_i & off_mask)) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      glob_q  <= '0;
    end else begin
      unique case (op)
        OP_DROP_ALL:   valid_q <= '0;
        OP_DROP_LOCAL: valid_q <= valid_q & glob_q;
        OP_DEMAP:      if (any_hit) valid_q[hit_idx] <= 1'b0;
        OP_INSERT: begin
          valid_q[ins_slot] <= 1'b1;
          glob_q[ins_slot]  <= ins_global_i;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (op == OP_INSERT) begin
      vbase_q[ins_slot] <= ins_va_i;
      pbase_q[ins_slot] <= ins_pa_i;
      ord_q[ins_slot]   <= ins_order_i;
    end
  end
endmodule

// File: rtl/tlbf_chk.sv
module tlbf_chk #(
  parameter int N_ENTRIES = 16,
  parameter int ADDR_W    = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [ADDR_W-1:0]    lookup_va_i,
  input logic                 lookup_touch_i,
  input logic                 hit_o,
  input logic                 ins_valid_i,
  input logic [ADDR_W-1:0]    ins_va_i,
  input logic                 flush_all_i,
  input logic                 flush_local_i,
  input logic                 demap_i,
  input logic [N_ENTRIES-1:0] valid_q,
  input logic [N_ENTRIES-1:0] glob_q
);
  // R10: one state-changing request per cycle
  a_r10_one_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ins_valid_i, lookup_touch_i, demap_i, flush_local_i, flush_all_i}));

  a_r1_miss_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q == '0) |-> !hit_o);

  a_r7_flush_all_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> (valid_q == '0));

  a_r8_local_keeps_global: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_local_i |=> (valid_q == ($past(valid_q) & $past(glob_q))));

  a_r4_insert_occupancy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_i |=> ($countones(valid_q) ==
      (($past($countones(valid_q)) == N_ENTRIES) ? N_ENTRIES : $past($countones(valid_q)) + 1)));

  a_r2_insert_then_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_i |=> (lookup_va_i != $past(ins_va_i)) || hit_o);

  a_r9_demap_frees_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (demap_i && hit_o) |=> ($countones(valid_q) == $past($countones(valid_q)) - 1));
endmodule

bind tlb_lru_cache tlbf_chk #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lookup_va_i(lookup_va_i),
  .lookup_touch_i(lookup_touch_i), .hit_o(hit_o), .ins_valid_i(ins_valid_i),
  .ins_va_i(ins_va_i), .flush_all_i(flush_all_i), .flush_local_i(flush_local_i),
  .demap_i(demap_i), .valid_q(valid_q), .glob_q(glob_q)
);

// File: tb/tlb_lru_cache_tb.sv
module tlb_lru_cache_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int AW = 32;
  localparam int OW = $clog2(AW);

  localparam int K_NONE = 0, K_INS = 1, K_TCH = 2, K_DEM = 3, K_FNG = 4, K_FAL = 5;

  logic clk = 0, rst_ni = 0;
  logic [AW-1:0] lookup_va = '0, ins_va = '0, ins_pa = '0;
  logic [OW-1:0] ins_order = '0;
  logic lookup_touch = 0, ins_valid = 0, ins_global = 0;
  logic flush_all = 0, flush_local = 0, demap = 0;
  logic hit;
  logic [AW-1:0] pa;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tlb_lru_cache #(.N_ENTRIES(N), .ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .lookup_va_i(lookup_va), .lookup_touch_i(lookup_touch),
    .hit_o(hit), .pa_o(pa), .ins_valid_i(ins_valid), .ins_va_i(ins_va), .ins_pa_i(ins_pa),
    .ins_order_i(ins_order), .ins_global_i(ins_global), .flush_all_i(flush_all),
    .flush_local_i(flush_local), .demap_i(demap)
  );

  // Behavioural model: slot contents plus a recency queue (front = newest)
  bit          mv [N];
  bit          mg [N];
  longint      mb [N];
  longint      mp [N];
  int          mo [N];
  int          lru [$];
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;
  string       req = "R1";
  longint      rb [8];
  int          ro [8];
  int          rcnt = 0;

  function automatic int find(longint va);
    for (int i = 0; i < N; i++)
      if (mv[i] && mb[i] <= va && va < mb[i] + (longint'(1) << mo[i])) return i;
    return -1;
  endfunction

  function automatic void qremove(int s);
    for (int k = 0; k < lru.size(); k++)
      if (lru[k] == s) begin lru.delete(k); return; end
  endfunction

  function automatic void apply(int op, longint lva, longint iva, longint ipa, int ord, bit g);
    int h;
    int s;
    case (op)
      K_INS: begin
        s = -1;
        for (int i = 0; i < N; i++) if (!mv[i] && s < 0) s = i;
        if (s < 0) begin s = lru[$]; void'(lru.pop_back()); end
        mv[s] = 1; mg[s] = g; mb[s] = iva; mp[s] = ipa; mo[s] = ord;
        lru.push_front(s);
      end
      K_TCH: begin
        h = find(lva);
        if (h >= 0) begin qremove(h); lru.push_front(h); end
      end
      K_DEM: begin
        h = find(lva);
        if (h >= 0) begin mv[h] = 0; qremove(h); end
      end
      K_FNG: for (int i = 0; i < N; i++) if (mv[i] && !mg[i]) begin mv[i] = 0; qremove(i); end
      K_FAL: begin for (int i = 0; i < N; i++) mv[i] = 0; lru.delete(); end
      default: ;
    endcase
  endfunction

  task automatic compare();
    int h;
    logic exp_hit;
    logic [AW-1:0] exp_pa;
    h = find(longint'(lookup_va));
    exp_hit = (h >= 0);
    exp_pa = '0;
    if (h >= 0) exp_pa = AW'(mp[h] | (longint'(lookup_va) & ((longint'(1) << mo[h]) - 1)));
    n_chk++;
    if (hit !== exp_hit || pa !== exp_pa) begin
      n_bad++;
      $display("FAIL %s va=%h hit=%b pa=%h expected hit=%b pa=%h",
               req, lookup_va, hit, pa, exp_hit, exp_pa);
    end
  endtask

  task automatic cyc(int op, logic [AW-1:0] lva, logic [AW-1:0] iva = '0,
                     logic [AW-1:0] ipa = '0, int ord = 12, bit g = 0);
    @(negedge clk);
    lookup_va    = lva;
    lookup_touch = (op == K_TCH);
    ins_valid    = (op == K_INS);
    demap        = (op == K_DEM);
    flush_local  = (op == K_FNG);
    flush_all    = (op == K_FAL);
    ins_va = iva; ins_pa = ipa; ins_order = OW'(ord); ins_global = g;
    #1 compare();
    @(posedge clk);
    apply(op, longint'(lva), longint'(iva), longint'(ipa), ord, g);
    if (op == K_INS) begin rb[rcnt % 8] = longint'(iva); ro[rcnt % 8] = ord; rcnt++; end
  endtask

  task automatic look(logic [AW-1:0] va);
    cyc(K_NONE, va);
  endtask

  function automatic logic [AW-1:0] pick_va();
    int k;
    longint sz;
    if (rcnt == 0) return AW'($urandom_range(0, 32'h000F_FFFF));
    k = $urandom_range(0, (rcnt < 8 ? rcnt : 8) - 1);
    sz = longint'(1) << ro[k];
    case ($urandom_range(0, 4))
      0: return AW'(rb[k]);
      1: return AW'(rb[k] + sz - 1);
      2: return AW'(rb[k] + sz);
      3: return AW'(rb[k] - 1);
      default: return AW'(rb[k] + longint'($urandom_range(0, 32'(sz - 1))));
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired during %s", req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) mv[i] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;

    req = "R1";
    for (int i = 0; i < 6; i++) look(AW'(i * 32'h1000));
    look('1);

    req = "R2";
    cyc(K_INS, 32'h0000_3000, 32'h0000_3000, 32'h8000_0000, 12);
    look(32'h0000_2FFF); look(32'h0000_3000); look(32'h0000_3FFF); look(32'h0000_4000);
    cyc(K_INS, 32'h0002_0000, 32'h0002_0000, 32'h0100_0000, 16, 1);
    look(32'h0002_FFFF); look(32'h0003_0000); look(32'h0001_FFFF);

    req = "R3";
    cyc(K_FAL, '0);
    cyc(K_INS, '0, 32'h0004_0000, 32'h0010_0000, 16);
    cyc(K_INS, '0, 32'h0004_1000, 32'h0090_0000, 12);
    look(32'h0004_1234); look(32'h0004_0ABC); look(32'h0005_0000);

    req = "R9";
    cyc(K_DEM, 32'h0004_1234);
    look(32'h0004_1234); look(32'h0004_5678);
    cyc(K_DEM, 32'h0004_1234);
    look(32'h0004_1234);
    cyc(K_DEM, 32'h0007_0000);
    look(32'h0007_0000);

    req = "R4";
    cyc(K_FAL, '0);
    for (int i = 0; i < N; i++)
      cyc(K_INS, '0, AW'(i << 12), AW'(32'h8000_0000 | (i << 12)), 12);
    cyc(K_INS, '0, 32'h0010_0000, 32'h4000_0000, 12);
    for (int i = 0; i < N; i++) look(AW'((i << 12) + 5));
    look(32'h0010_0010);

    req = "R5";
    cyc(K_INS, '0, 32'h0011_0000, 32'h4100_0000, 12);
    cyc(K_INS, '0, 32'h0012_0000, 32'h4200_0000, 12);
    look(32'h0010_0000); look(32'h0011_0000); look(32'h0012_0000); look(32'h0000_2000);

    req = "R6";
    cyc(K_TCH, 32'h0000_3004);
    look(32'h0000_4004);
    cyc(K_INS, '0, 32'h0013_0000, 32'h4300_0000, 12);
    look(32'h0000_3004); look(32'h0000_4004);
    cyc(K_TCH, 32'h00F0_0000);
    cyc(K_INS, '0, 32'h0014_0000, 32'h4400_0000, 12);
    look(32'h0000_5004); look(32'h0000_6004);

    req = "R8";
    cyc(K_FAL, '0);
    cyc(K_INS, '0, 32'h0000_1000, 32'h0A00_0000, 12, 1);
    cyc(K_INS, '0, 32'h0000_2000, 32'h0B00_0000, 12, 0);
    cyc(K_INS, '0, 32'h0001_0000, 32'h0C00_0000, 16, 1);
    cyc(K_FNG, '0);
    look(32'h0000_1FFF); look(32'h0000_2000); look(32'h0001_8000);

    req = "R7";
    cyc(K_FAL, '0);
    look(32'h0000_1000); look(32'h0001_8000);

    req = "R10";
    for (int t = 0; t < 4000; t++) begin
      int sel;
      int ord;
      logic [AW-1:0] va;
      sel = $urandom_range(0, 99);
      va = pick_va();
      ord = $urandom_range(8, 16);
      if (sel < 30)
        cyc(K_INS, va, AW'($urandom_range(0, 63) << ord),
            AW'(32'h8000_0000 | ($urandom_range(0, 1023) << ord)), ord, bit'($urandom_range(0, 1)));
      else if (sel < 31) cyc(K_FAL, va);
      else if (sel < 33) cyc(K_FNG, va);
      else if (sel < 43) cyc(K_DEM, va);
      else if (sel < 63) cyc(K_TCH, va);
      else look(va);
    end
    look(pick_va());

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule